// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel TFT panel. It also outputs the current pixel column and line, a one-cycle end-of-frame strobe and a frame-done strobe. It runs on the system clock and moves forward one pixel position on each clock where the pixel-clock enable is high. The clock divider that makes that enable is outside the block, and so are the pixel data path and the frame-buffer fetch.

Timing comes from packed configuration fields in the compact encodings the controller's registers use:

- The active width is stored in units of 16 pixels, minus one.
- Horizontal porches and the horizontal sync width are stored minus one. Each is split into a low field and a high extension field.
- Vertical porches are stored as plain line counts. The vertical sync width is stored minus one.
- The line count is stored minus one. Its bit 10 sits in a separate extension field.

The decoded timing is captured when a frame starts, so software may rewrite the fields at any time. A rewrite takes effect at the next frame boundary.

Each line runs active pixels first, then front porch, then sync, then back porch. Each frame uses the same order in lines.

Raster enable starts the scan from an idle state. When raster enable is cleared, the frame in progress finishes, then the block returns to idle with both counters at zero and pulses frame-done. None of the outputs is a data stream, so no valid/ready handshake exists and nothing can apply back-pressure. The panel side must accept every strobe as it comes.

Top module: `lcdt_raster_top`

## Requirements
- R1: Active pixels per line equal (cfg_hact + 1) * 16. cfg_hact is 7 bits; bit 6 is honoured only when parameter EXTENDED is 1, giving at most 2048 pixels, and is treated as 0 otherwise, giving at most 1024 pixels.
- R2: Horizontal front porch, back porch and sync width in pixels equal the concatenation {hi, lo} + 1. The porches use an 8-bit lo field and a 2-bit hi field. The sync width uses a 6-bit lo field and a 4-bit hi field. The hi fields read as 0 when EXTENDED is 0.
- R3: Vertical front and back porch lengths in lines equal cfg_vfp and cfg_vbp exactly, and 0 is allowed. Vertical sync length equals cfg_vsw + 1. Active lines equal {cfg_lines_hi, cfg_lines_lo} + 1, with the hi bit read as 0 when EXTENDED is 0.
- R4: While running, x counts 0 to htotal-1 and then wraps. y advances when x wraps and itself wraps after vtotal-1. Each line is active, front porch, sync, back porch in that order, and each frame uses the same order in lines.
- R5: de is 1 exactly when running with x inside the active pixels and y inside the active lines.
- R6: hsync equals (x in horizontal sync) XOR the captured hsync invert bit, and vsync equals (y in vertical sync) XOR the captured vsync invert bit. An invert bit of 0 means an active-high pulse. While idle, each sync output sits at its live invert input.
- R7: x, y and the running state change only on clocks where pix_ce is 1.
- R8: When idle and raster_en is 1 on a pix_ce clock, running begins at x = y = 0 on the next clock. The configuration is captured on that clock and at every frame wrap, and a change made during a frame does not affect that frame.
- R9: eof is 1 for exactly the clock where pix_ce is 1 and the position is the last active pixel of the last active line.
- R10: If raster_en is 0 at the frame wrap, running stops with x = y = 0 and de = 0. frame_done is 1 for the single clock after that edge. Idle holds until raster_en is 1 again.
- R11: After reset the block is idle: x = 0, y = 0, de = 0, eof = 0 and frame_done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; one pixel position per high clock |
| raster_en | input | 1 | Run request; when cleared, the frame in progress still completes |
| cfg_hact | input | 7 | Active width in 16-pixel units, minus one |
| cfg_hfp_lo | input | 8 | Horizontal front porch minus one, low bits |
| cfg_hfp_hi | input | 2 | Horizontal front porch minus one, high bits |
| cfg_hbp_lo | input | 8 | Horizontal back porch minus one, low bits |
| cfg_hbp_hi | input | 2 | Horizontal back porch minus one, high bits |
| cfg_hsw_lo | input | 6 | Horizontal sync width minus one, low bits |
| cfg_hsw_hi | input | 4 | Horizontal sync width minus one, high bits |
| cfg_lines_lo | input | 10 | Active lines minus one, low bits |
| cfg_lines_hi | input | 1 | Active lines minus one, bit 10 |
| cfg_vfp | input | 8 | Vertical front porch in lines |
| cfg_vbp | input | 8 | Vertical back porch in lines |
| cfg_vsw | input | 6 | Vertical sync width minus one |
| cfg_hs_inv | input | 1 | Invert hsync (1 gives an active-low pulse) |
| cfg_vs_inv | input | 1 | Invert vsync (1 gives an active-low pulse) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x | output | 13 | Current pixel column |
| y | output | 12 | Current line |
| eof | output | 1 | End-of-frame strobe at the last active pixel |
| frame_done | output | 1 | One-clock strobe when a stop takes effect |

## Verification
The assertions check the following on every cycle:

- The position holds on clocks without pix_ce.
- x steps by one inside a line.
- Idle means the origin with de low.
- eof falls on an active pixel and never repeats on the next clock.
- frame_done is a single clock that follows a running state.
- de never reaches past the widest allowed line.

Only the bench's scenarios can show the rest: the decoding of each packed field into segment lengths, the active, porch and sync order on both axes, and the sync polarities. The same applies to capture of the configuration only at frame boundaries, an enable gap pattern, and a stop that lands mid-frame. The bench's behavioural model shows these cycle by cycle.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // configuration field widths (register encodings)
  localparam int HACT_FW     = 7;
  localparam int HPORCH_LO_W = 8;
  localparam int HPORCH_HI_W = 2;
  localparam int HSW_LO_W    = 6;
  localparam int HSW_HI_W    = 4;
  localparam int LINES_LO_W  = 10;
  localparam int LINES_HI_W  = 1;
  localparam int VPORCH_W    = 8;
  localparam int VSW_W       = 6;
  // counter widths sized for the largest decoded totals
  localparam int H_W         = 13;
  localparam int V_W         = 12;
  localparam int MAX_HACT    = 2048;

  typedef struct packed {
    logic [H_W-1:0] h_act;
    logic [H_W-1:0] h_fp;
    logic [H_W-1:0] h_sw;
    logic [H_W-1:0] h_bp;
    logic [V_W-1:0] v_act;
    logic [V_W-1:0] v_fp;
    logic [V_W-1:0] v_sw;
    logic [V_W-1:0] v_bp;
    logic           hs_inv;
    logic           vs_inv;
  } lcdt_timing_t;
endpackage

// File: rtl/lcdt_cfg_decode.sv
module lcdt_cfg_decode
  import lcdt_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic [HACT_FW-1:0]     hact_f,
  input  logic [HPORCH_LO_W-1:0] hfp_lo,
  input  logic [HPORCH_HI_W-1:0] hfp_hi,
  input  logic [HPORCH_LO_W-1:0] hbp_lo,
  input  logic [HPORCH_HI_W-1:0] hbp_hi,
  input  logic [HSW_LO_W-1:0]    hsw_lo,
  input  logic [HSW_HI_W-1:0]    hsw_hi,
  input  logic [LINES_LO_W-1:0]  lines_lo,
  input  logic [LINES_HI_W-1:0]  lines_hi,
  input  logic [VPORCH_W-1:0]    vfp_f,
  input  logic [VPORCH_W-1:0]    vbp_f,
  input  logic [VSW_W-1:0]       vsw_f,
  input  logic                   hs_inv,
  input  logic                   vs_inv,
  output lcdt_timing_t           tim
);
  logic [HACT_FW-1:0]     hact_eff;
  logic [HPORCH_HI_W-1:0] hfp_hi_eff, hbp_hi_eff;
  logic [HSW_HI_W-1:0]    hsw_hi_eff;
  logic [LINES_HI_W-1:0]  lines_hi_eff;

  // the base variant ignores every extension bit
  generate
    if (EXTENDED) begin : g_ext
      assign hact_eff     = hact_f;
      assign hfp_hi_eff   = hfp_hi;
      assign hbp_hi_eff   = hbp_hi;
      assign hsw_hi_eff   = hsw_hi;
      assign lines_hi_eff = lines_hi;
    end else begin : g_base
      assign hact_eff     = {1'b0, hact_f[HACT_FW-2:0]};
      assign hfp_hi_eff   = '0;
      assign hbp_hi_eff   = '0;
      assign hsw_hi_eff   = '0;
      assign lines_hi_eff = '0;
    end
  endgenerate

  always_comb begin
    tim.h_act  = H_W'({hact_eff, 4'b0000}) + H_W'(16);
    tim.h_fp   = H_W'({hfp_hi_eff, hfp_lo}) + H_W'(1);
    tim.h_bp   = H_W'({hbp_hi_eff, hbp_lo}) + H_W'(1);
    tim.h_sw   = H_W'({hsw_hi_eff, hsw_lo}) + H_W'(1);
    tim.v_act  = V_W'({lines_hi_eff, lines_lo}) + V_W'(1);
    tim.v_fp   = V_W'(vfp_f);
    tim.v_bp   = V_W'(vbp_f);
    tim.v_sw   = V_W'(vsw_f) + V_W'(1);
    tim.hs_inv = hs_inv;
    tim.vs_inv = vs_inv;
  end
endmodule

// File: rtl/lcdt_axis_ctr.sv
module lcdt_axis_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_fp,
  input  logic [W-1:0] len_sw,
  input  logic [W-1:0] len_bp,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         in_act,
  output logic         act_last,
  output logic         in_sync
);
  logic [W-1:0] sync_lo, sync_hi, total_m1;

  // segment order: active, front porch, sync, back porch
  assign sync_lo  = len_act + len_fp;
  assign sync_hi  = sync_lo + len_sw;
  assign total_m1 = sync_hi + len_bp - W'(1);

  assign last     = (pos == total_m1);
  assign in_act   = (pos < len_act);
  assign act_last = (pos == len_act - W'(1));
  assign in_sync  = (pos >= sync_lo) && (pos < sync_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= last ? '0 : pos + W'(1);
  end
endmodule

// File: rtl/lcdt_raster_top.sv
module lcdt_raster_top
  import lcdt_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_ce,
  input  logic                   raster_en,
  input  logic [HACT_FW-1:0]     cfg_hact,
  input  logic [HPORCH_LO_W-1:0] cfg_hfp_lo,
  input  logic [HPORCH_HI_W-1:0] cfg_hfp_hi,
  input  logic [HPORCH_LO_W-1:0] cfg_hbp_lo,
  input  logic [HPORCH_HI_W-1:0] cfg_hbp_hi,
  input  logic [HSW_LO_W-1:0]    cfg_hsw_lo,
  input  logic [HSW_HI_W-1:0]    cfg_hsw_hi,
  input  logic [LINES_LO_W-1:0]  cfg_lines_lo,
  input  logic [LINES_HI_W-1:0]  cfg_lines_hi,
  input  logic [VPORCH_W-1:0]    cfg_vfp,
  input  logic [VPORCH_W-1:0]    cfg_vbp,
  input  logic [VSW_W-1:0]       cfg_vsw,
  input  logic                   cfg_hs_inv,
  input  logic                   cfg_vs_inv,
  output logic                   hsync,
  output logic                   vsync,
  output logic                   de,
  output logic [H_W-1:0]         x,
  output logic [V_W-1:0]         y,
  output logic                   eof,
  output logic                   frame_done
);
  lcdt_timing_t dec_tim, cur_tim;
  logic run_q, fdone_q;
  logic h_last, h_act, h_act_last, h_sync;
  logic v_last, v_act, v_act_last, v_sync;
  logic h_step, v_step, frame_end, start, load;

  lcdt_cfg_decode #(.EXTENDED(EXTENDED)) u_dec (
    .hact_f(cfg_hact), .hfp_lo(cfg_hfp_lo), .hfp_hi(cfg_hfp_hi),
    .hbp_lo(cfg_hbp_lo), .hbp_hi(cfg_hbp_hi),
    .hsw_lo(cfg_hsw_lo), .hsw_hi(cfg_hsw_hi),
    .lines_lo(cfg_lines_lo), .lines_hi(cfg_lines_hi),
    .vfp_f(cfg_vfp), .vbp_f(cfg_vbp), .vsw_f(cfg_vsw),
    .hs_inv(cfg_hs_inv), .vs_inv(cfg_vs_inv), .tim(dec_tim)
  );

  assign h_step    = pix_ce & run_q;
  assign v_step    = h_step & h_last;
  assign frame_end = v_step & v_last;
  assign start     = pix_ce & ~run_q & raster_en;
  assign load      = start | (frame_end & raster_en);

  lcdt_axis_ctr #(.W(H_W)) u_hctr (
    .clk(clk), .rst_n(rst_n), .step(h_step),
    .len_act(cur_tim.h_act), .len_fp(cur_tim.h_fp),
    .len_sw(cur_tim.h_sw), .len_bp(cur_tim.h_bp),
    .pos(x), .last(h_last), .in_act(h_act),
    .act_last(h_act_last), .in_sync(h_sync)
  );

  lcdt_axis_ctr #(.W(V_W)) u_vctr (
    .clk(clk), .rst_n(rst_n), .step(v_step),
    .len_act(cur_tim.v_act), .len_fp(cur_tim.v_fp),
    .len_sw(cur_tim.v_sw), .len_bp(cur_tim.v_bp),
    .pos(y), .last(v_last), .in_act(v_act),
    .act_last(v_act_last), .in_sync(v_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fdone_q <= 1'b0;
      cur_tim <= '0;
    end else begin
      fdone_q <= frame_end & ~raster_en;
      if (load) cur_tim <= dec_tim;
      if (start)                        run_q <= 1'b1;
      else if (frame_end && !raster_en) run_q <= 1'b0;
    end
  end

  assign de         = run_q & h_act & v_act;
  assign hsync      = run_q ? (h_sync ^ cur_tim.hs_inv) : cfg_hs_inv;
  assign vsync      = run_q ? (v_sync ^ cur_tim.vs_inv) : cfg_vs_inv;
  assign eof        = run_q & pix_ce & h_act_last & v_act_last;
  assign frame_done = fdone_q;
endmodule

// File: rtl/lcdt_raster_chk.sv
module lcdt_raster_chk
  import lcdt_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           pix_ce,
  input logic           run_q,
  input logic           h_last,
  input logic           de,
  input logic           eof,
  input logic           frame_done,
  input logic [H_W-1:0] x,
  input logic [V_W-1:0] y
);
  assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> ($stable(x) && $stable(y) && $stable(run_q)));

  assert_idle_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (x == '0 && y == '0 && !de));

  assert_eof_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> (de && pix_ce));

  assert_eof_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);

  assert_fdone_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!run_q && $past(run_q)));

  assert_fdone_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_de_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (int'(x) < MAX_HACT));

  assert_x_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && run_q && !h_last) |=> (x == H_W'($past(x) + 1'b1)));
endmodule

bind lcdt_raster_top lcdt_raster_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .run_q(run_q),
  .h_last(h_last), .de(de), .eof(eof), .frame_done(frame_done),
  .x(x), .y(y)
);

// File: tb/lcdt_raster_top_tb.sv
module lcdt_raster_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic raster_en = 1'b0;
  logic [6:0] cfg_hact = '0;
  logic [7:0] cfg_hfp_lo = '0, cfg_hbp_lo = '0;
  logic [1:0] cfg_hfp_hi = '0, cfg_hbp_hi = '0;
  logic [5:0] cfg_hsw_lo = '0;
  logic [3:0] cfg_hsw_hi = '0;
  logic [9:0] cfg_lines_lo = '0;
  logic [0:0] cfg_lines_hi = '0;
  logic [7:0] cfg_vfp = '0, cfg_vbp = '0;
  logic [5:0] cfg_vsw = '0;
  logic cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0;
  logic hsync, vsync, de, eof, frame_done;
  logic [12:0] x;
  logic [11:0] y;

  int vectors = 0;
  int miscompares = 0;
  int fd_seen = 0;
  bit chk_on = 1'b0;
  bit ce_rand = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  // reference model state
  bit m_run = 0;
  bit m_fd = 0;
  int m_h = 0, m_v = 0;
  int ha, hf, hw, hb, va, vf, vw, vb;
  bit hinv, vinv;

  always #4 clk = ~clk;

  lcdt_raster_top dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .raster_en(raster_en),
    .cfg_hact(cfg_hact), .cfg_hfp_lo(cfg_hfp_lo), .cfg_hfp_hi(cfg_hfp_hi),
    .cfg_hbp_lo(cfg_hbp_lo), .cfg_hbp_hi(cfg_hbp_hi),
    .cfg_hsw_lo(cfg_hsw_lo), .cfg_hsw_hi(cfg_hsw_hi),
    .cfg_lines_lo(cfg_lines_lo), .cfg_lines_hi(cfg_lines_hi),
    .cfg_vfp(cfg_vfp), .cfg_vbp(cfg_vbp), .cfg_vsw(cfg_vsw),
    .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
    .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y),
    .eof(eof), .frame_done(frame_done)
  );

  task automatic check(input string req, input string sig, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
    end
  endtask

  // decode from the requirement text (R1, R2, R3)
  task automatic capture_cfg();
    ha = (int'(cfg_hact) + 1) * 16;
    hf = int'(cfg_hfp_hi) * 256 + int'(cfg_hfp_lo) + 1;
    hb = int'(cfg_hbp_hi) * 256 + int'(cfg_hbp_lo) + 1;
    hw = int'(cfg_hsw_hi) * 64 + int'(cfg_hsw_lo) + 1;
    va = int'(cfg_lines_hi) * 1024 + int'(cfg_lines_lo) + 1;
    vf = int'(cfg_vfp);
    vb = int'(cfg_vbp);
    vw = int'(cfg_vsw) + 1;
    hinv = cfg_hs_inv;
    vinv = cfg_vs_inv;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_fd = 0;
    end else begin
      m_fd = 0;
      if (pix_ce) begin
        if (!m_run) begin
          if (raster_en) begin m_run = 1; capture_cfg(); end
        end else if (m_h == ha + hf + hw + hb - 1) begin
          m_h = 0;
          if (m_v == va + vf + vw + vb - 1) begin
            m_v = 0;
            if (raster_en) capture_cfg();
            else begin m_run = 0; m_fd = 1; end
          end else m_v++;
        end else m_h++;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      bit e_de, e_hs, e_vs, e_eof;
      e_de  = m_run && m_h < ha && m_v < va;
      e_hs  = m_run ? ((m_h >= ha + hf && m_h < ha + hf + hw) ^ hinv) : cfg_hs_inv;
      e_vs  = m_run ? ((m_v >= va + vf && m_v < va + vf + vw) ^ vinv) : cfg_vs_inv;
      e_eof = m_run && pix_ce && m_h == ha - 1 && m_v == va - 1;
      check("R4/R7/R8", "x", int'(x), m_h);
      check("R4/R7/R8", "y", int'(y), m_v);
      check("R1/R3/R5", "de", int'(de), int'(e_de));
      check("R2/R6", "hsync", int'(hsync), int'(e_hs));
      check("R3/R6", "vsync", int'(vsync), int'(e_vs));
      check("R9", "eof", int'(eof), int'(e_eof));
      check("R10", "frame_done", int'(frame_done), int'(m_fd));
      if (frame_done) fd_seen++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pix_ce = ce_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  endtask

  task automatic set_cfg(input int hact, input int hfpe, input int hswe, input int hbpe,
                         input int lines, input int vfpv, input int vswe, input int vbpv,
                         input bit hi, input bit vi);
    cfg_hact     = 7'(hact);
    cfg_hfp_lo   = 8'(hfpe & 255);  cfg_hfp_hi = 2'(hfpe >> 8);
    cfg_hbp_lo   = 8'(hbpe & 255);  cfg_hbp_hi = 2'(hbpe >> 8);
    cfg_hsw_lo   = 6'(hswe & 63);   cfg_hsw_hi = 4'(hswe >> 6);
    cfg_lines_lo = 10'(lines & 1023); cfg_lines_hi = 1'(lines >> 10);
    cfg_vfp = 8'(vfpv); cfg_vbp = 8'(vbpv); cfg_vsw = 6'(vswe);
    cfg_hs_inv = hi; cfg_vs_inv = vi;
  endtask

  task automatic stop_and_wait();
    raster_en = 1'b0;
    fd_seen = 0;
    for (int i = 0; i < 30000 && m_run; i++) tick(1);
    tick(3);
    check("R10", "frame_done pulses", fd_seen, 1);
    check("R10", "idle x", int'(x), 0);
    check("R10", "idle de", int'(de), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    set_cfg(0, 1, 2, 0, 2, 1, 1, 0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "reset x", int'(x), 0);
    check("R11", "reset y", int'(y), 0);
    check("R11", "reset de", int'(de), 0);
    check("R11", "reset eof", int'(eof), 0);
    check("R11", "reset frame_done", int'(frame_done), 0);
    check("R11", "reset hsync idle level", int'(hsync), 0);
    chk_on = 1'b1;
    tick(5);                      // idle with pix_ce, raster_en low
    raster_en = 1'b1;
    tick(300);                    // small frames, continuous enable
    ce_rand = 1'b1;
    tick(400);                    // gapped pixel enable (R7)
    // mid-frame rewrite: extension bits, inverted polarity, zero porches (R8)
    set_cfg(1, 258, 70, 0, 1, 0, 0, 3, 1'b1, 1'b1);
    ce_rand = 1'b0;
    tick(4000);
    stop_and_wait();
    tick(20);
    // widest line width bit (R1)
    set_cfg(64, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
    raster_en = 1'b1;
    tick(2200);
    stop_and_wait();
    // line-count extension bit (R3)
    set_cfg(0, 0, 0, 0, 1024, 2, 0, 1, 1'b1, 1'b0);
    raster_en = 1'b1;
    tick(200);
    stop_and_wait();
    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule